// File: doc/BRIEF.md
# Interval Timer with Prescaler Tick

This block is a programmable interval timer. A 14-bit binary divider counts either every system clock cycle or once per rising edge of a slow sub-clock. One of eight divider bits is selected as the timer output. That bit passes through a two-flop synchroniser and a rising-edge detector. The result is a single-cycle tick in the system clock domain. The tick feeds other timers, a serial interface and a watchdog as their prescaler.

The same tick can also set a sticky interrupt flag. The flag can be masked, and a clear strobe resets it. A bypass control routes the synchronised sub-clock around the divider. A sleep input, for sleep with the oscillator stopped, holds the prescaler tick at zero. In sleep the divider keeps counting and interrupts are still raised.

The whole block runs on the system clock. The sub-clock is a sampled data input that is at least a few system cycles per phase.

Top module: `itimer_top`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `tick_out` and `irq` are 0, and the divider restarts from zero.
- R2: With `src_sel`=0 (system clock) and `bypass`=0, `tick_out` pulses once every D system cycles. For `ivl_sel` codes 0 to 7, D is 2, 4, 8, 16, 32, 64, 256 and 16384.
- R3: With `src_sel`=1 (sub-clock) and `bypass`=0, the divider advances once per sub-clock rising edge. The tick period is therefore D times the sub-clock period.
- R4: Every `tick_out` pulse lasts exactly one system cycle.
- R5: With `bypass`=1, the tick period equals the sub-clock period whatever `ivl_sel` and `src_sel` are.
- R6: While `sleep_stop`=1, `tick_out` stays 0. The divider keeps running and the interval event still sets `irq`. Ticks resume once `sleep_stop` returns to 0.
- R7: While `irq_mask`=1, an interval event does not set `irq`.
- R8: An unmasked interval event sets `irq` in the same cycle as its `tick_out` pulse. `irq` then stays 1 until a cycle with `irq_clr`=1 and no new event.
- R9: When an unmasked event and `irq_clr` fall in the same cycle, `irq` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Divider source: 0 system clock, 1 sub-clock edges |
| sub_clk | input | 1 | Slow sub-clock, sampled |
| bypass | input | 1 | 1 routes the sub-clock around the divider |
| ivl_sel | input | 3 | Interval code selecting the divider tap |
| irq_mask | input | 1 | 1 blocks interval events from setting the flag |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| sleep_stop | input | 1 | Sleep with oscillator stopped; forces the tick low |
| tick_out | output | 1 | One-cycle prescaler tick |
| irq | output | 1 | Sticky interval interrupt flag |

## Verification
The tick period is measured between two later pulses after each reset, so the phase at reset has no effect on the result. This measurement covers all eight interval codes from the system clock, and three codes from the sub-clock. Any wrong tap or divider width shows up as the wrong period, and a sub-clock run that ignores the edge enable gives a period eight times too short. Bypass runs use both values of the source select and different interval codes. They expect the sub-clock period each time, which separates the bypass path from the divider path. The interrupt tests place the clear strobe on a cycle without an event and on a cycle with one. They also combine mask and sleep with live events, to show that gating the tick does not stop the flag.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int SEL_W  = 3;
  localparam int N_TAPS = 1 << SEL_W;
  localparam int MIN_DIV_W = 14;

  // Divider bit used for each interval code; bit k gives period 2^(k+1)
  function automatic int unsigned tap_bit(input logic [SEL_W-1:0] code);
    case (code)
      3'd6:    tap_bit = 7;
      3'd7:    tap_bit = 13;
      default: tap_bit = int'(code);
    endcase
  endfunction
endpackage

// File: rtl/itimer_sync.sv
module itimer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      level <= 1'b0;
      rise  <= 1'b0;
    end else begin
      sh    <= {sh[STAGES-2:0], din};
      level <= sh[STAGES-1];
      rise  <= sh[STAGES-1] & ~level;
    end
  end
endmodule

// File: rtl/itimer_div.sv
module itimer_div #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/itimer_top.sv
module itimer_top
  import itimer_pkg::*;
#(
  parameter int DIV_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_sel,
  input  logic             sub_clk,
  input  logic             bypass,
  input  logic [SEL_W-1:0] ivl_sel,
  input  logic             irq_mask,
  input  logic             irq_clr,
  input  logic             sleep_stop,
  output logic             tick_out,
  output logic             irq
);
  logic             sub_lvl, sub_rise;
  logic             adv;
  logic [DIV_W-1:0] div_cnt;
  logic [N_TAPS-1:0] taps;
  logic             tap_lvl;
  logic             out_lvl, out_rise;

  itimer_sync #(.STAGES(SYNC_STAGES)) u_sub_sync (
    .clk(clk), .rst(rst), .din(sub_clk), .level(sub_lvl), .rise(sub_rise)
  );

  assign adv = src_sel ? sub_rise : 1'b1;

  itimer_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .en(adv), .cnt(div_cnt)
  );

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    assign taps[g] = div_cnt[tap_bit(SEL_W'(g))];
  end

  assign tap_lvl = bypass ? sub_lvl : taps[ivl_sel];

  itimer_sync #(.STAGES(SYNC_STAGES)) u_out_sync (
    .clk(clk), .rst(rst), .din(tap_lvl), .level(out_lvl), .rise(out_rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_out <= 1'b0;
      irq      <= 1'b0;
    end else begin
      tick_out <= out_rise & ~sleep_stop;
      irq      <= (out_rise & ~irq_mask) | (irq & ~irq_clr);
    end
  end
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk (
  input logic clk,
  input logic rst,
  input logic irq_mask,
  input logic irq_clr,
  input logic sleep_stop,
  input logic tick_out,
  input logic irq,
  input logic out_rise,
  input logic out_lvl
);
  // R4
  single_cycle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tick_out |=> !tick_out);
  // R6
  sleep_gates_tick_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_stop |=> !tick_out);
  // R7
  mask_blocks_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && irq_mask) |=> !irq);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  // R8
  flag_set_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(out_rise && !irq_mask));
  // R4
  rise_has_level_chk: assert property (@(posedge clk) disable iff (rst)
    out_rise |-> out_lvl);
endmodule

bind itimer_top itimer_chk u_chk (
  .clk(clk), .rst(rst), .irq_mask(irq_mask), .irq_clr(irq_clr),
  .sleep_stop(sleep_stop), .tick_out(tick_out), .irq(irq),
  .out_rise(out_rise), .out_lvl(out_lvl)
);

// File: tb/itimer_top_tb_top.sv
module itimer_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_sel = 1'b0, sub_clk = 1'b0, bypass = 1'b0;
  logic [2:0] ivl_sel = 3'd0;
  logic irq_mask = 1'b0, irq_clr = 1'b0, sleep_stop = 1'b0;
  logic tick_out, irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  itimer_top dut_i (
    .clk(clk), .rst(rst), .src_sel(src_sel), .sub_clk(sub_clk), .bypass(bypass),
    .ivl_sel(ivl_sel), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .sleep_stop(sleep_stop), .tick_out(tick_out), .irq(irq)
  );

  // sub-clock: 4 system cycles per phase, period 8
  initial forever begin
    repeat (4) @(negedge clk);
    sub_clk = ~sub_clk;
  end

  // {src_sel, bypass, ivl_sel, expected period}
  localparam int NV = 13;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 20'd2},    {1'b0, 1'b0, 3'd1, 20'd4},
    {1'b0, 1'b0, 3'd2, 20'd8},    {1'b0, 1'b0, 3'd3, 20'd16},
    {1'b0, 1'b0, 3'd4, 20'd32},   {1'b0, 1'b0, 3'd5, 20'd64},
    {1'b0, 1'b0, 3'd6, 20'd256},  {1'b0, 1'b0, 3'd7, 20'd16384},
    {1'b1, 1'b0, 3'd0, 20'd16},   {1'b1, 1'b0, 3'd3, 20'd128},
    {1'b1, 1'b0, 3'd6, 20'd2048},
    {1'b1, 1'b1, 3'd5, 20'd8},    {1'b0, 1'b1, 3'd2, 20'd8}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_tick(input int lim, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_out && n < lim);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    @(negedge clk);
    check(tick_out == 0 && irq == 0, "R1 reset outputs", {tick_out, irq}, 0);
    do_reset();
    check(tick_out == 0 && irq == 0, "R1 after reset", {tick_out, irq}, 0);

    // R2 / R3 / R5 / R4: period table
    for (int i = 0; i < NV; i++) begin
      int exp, lim;
      string tag;
      src_sel = VEC[i][24];
      bypass  = VEC[i][23];
      ivl_sel = VEC[i][22:20];
      exp     = int'(VEC[i][19:0]);
      lim     = exp * 2 + 64;
      tag     = bypass ? "R5 bypass period" : (src_sel ? "R3 sub period" : "R2 sys period");
      do_reset();
      wait_tick(lim, n);
      wait_tick(lim, n);
      @(negedge clk);
      check(tick_out == 0, "R4 pulse width", tick_out, 0);
      wait_tick(lim, n);
      check(n + 1 == exp, tag, n + 1, exp);
    end

    // R7 / R8 / R9: interrupt flag
    src_sel = 0; bypass = 0; ivl_sel = 3'd0; irq_mask = 1;
    do_reset();
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tick_out) n++;
    end
    check(irq == 0 && n > 0, "R7 masked events", irq, 0);
    irq_mask = 0;
    wait_tick(16, n);
    check(irq == 1, "R8 set with tick", irq, 1);
    irq_mask = 1; irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    check(irq == 0, "R8 clear", irq, 0);
    irq_mask = 0;
    wait_tick(16, n);
    irq_mask = 1;
    repeat (20) @(negedge clk);
    check(irq == 1, "R8 sticky", irq, 1);
    irq_mask = 0;
    wait_tick(16, n);
    @(negedge clk);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    check(irq == 1 && tick_out == 1, "R9 set beats clear", {irq, tick_out}, 3);

    // R6: sleep gating
    ivl_sel = 3'd1; irq_mask = 0;
    rst = 1; sleep_stop = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    n = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (tick_out) n++;
    end
    check(n == 0, "R6 tick held low", n, 0);
    check(irq == 1, "R6 irq in sleep", irq, 1);
    sleep_stop = 0;
    wait_tick(32, n);
    check(tick_out == 1, "R6 tick resumes", tick_out, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule